// File: doc/BRIEF.md
# Nine-bit framed serial transmitter

This block turns a byte write into one asynchronous serial frame on a single output line. Each frame carries a low start bit, the eight data bits with the least significant bit first, a ninth bit chosen by the writer, and a high stop bit. The ninth bit can act as a parity bit, an address marker or a second stop bit, depending on the system around the block.

Bit timing is set by an oversampling tick that arrives at sixteen times the bit rate. A free-running divide-by-16 counter turns that tick into one rollover per bit time. A write does not start a frame at once. It loads the shift register and raises a pending request. The frame starts at the next rollover, so every bit edge on the line stays aligned to the counter and not to the write. The end of the frame is found from the contents of the shift register, not from a bit counter. After the final shift a sticky completion flag is raised. It stays set until the surrounding logic clears it with a separate input.

Top module: `nbtx_serializer`

## Requirements
- R1: After reset, `txd` is 1 and `done` is 0.
- R2: A frame on `txd` is, in time order: one start bit of value 0, `wr_byte` bit 0 up to bit 7, the ninth bit, and a stop level of 1.
- R3: A rollover is every 16th cycle with `bit_tick` high, counted from reset. The start bit appears at the first rollover edge strictly after the write cycle. Each bit lasts exactly one rollover period, and `txd` changes only at rollover edges.
- R4: `done` rises at the 11th rollover edge after the write. At that same edge `txd` returns to 1.
- R5: `done` stays at 1 until `done_clr` is high for a cycle, after which it reads 0 on the next cycle.
- R6: A write while a request is pending or a frame is being sent is ignored. The frame in flight keeps its bits and its completion timing.
- R7: `txd` rests at 1 whenever no frame is being sent, including while a request waits for its rollover.
- R8: The ninth bit is taken from `bit9` in the write cycle. Later changes of `bit9` have no effect on the frame in flight.
- R9: A write issued in any cycle after the completing rollover starts a new frame at the next rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| wr_en | input | 1 | Write strobe for one byte |
| wr_byte | input | 8 | Data byte captured on the write |
| bit9 | input | 1 | Ninth frame bit captured on the write |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial output line, idles high |
| done | output | 1 | Sticky frame-complete flag |

## Verification
The hardest cases to reach from the ports are the edges of rollover alignment. One is a write that lands in the same cycle as a rollover, which must wait a full bit period. The other is a write that lands just after one. The stimulus reaches both by tracking the tick count it has driven since reset. It then forces the tick high, or waits for a rollover, before it issues the write. A second hard case is a write that arrives mid-frame or while a request waits. To reach it, writes with different data and ninth bit are injected at random points inside the frame, while `bit9` is toggled freely.

// File: rtl/nbtx_pkg.sv
package nbtx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_SHIFT = 2'd3
  } tx_phase_e;

endpackage

// File: rtl/nbtx_baud_div.sv
module nbtx_baud_div #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic roll
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign roll = tick && (cnt_q == LAST);

endmodule

// File: rtl/nbtx_shreg.sv
module nbtx_shreg #(
  parameter int SR_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SR_W-1:0] load_val,
  input  logic            shift,
  input  logic            fill,
  output logic            lsb,
  output logic            end_pat
);
  localparam logic [SR_W-2:0] MARK = (SR_W-1)'(1);

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {fill, sr_q[SR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign lsb     = sr_q[0];
  assign end_pat = (sr_q[SR_W-1:1] == MARK);

  AST_LOAD_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R6

endmodule

// File: rtl/nbtx_fsm.sv
module nbtx_fsm
  import nbtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic roll,
  input  logic wr_en,
  input  logic sr_lsb,
  input  logic end_pat,
  output logic load,
  output logic shift,
  output logic fill,
  output logic done_set,
  output logic txd
);
  tx_phase_e phase_q, phase_d;
  logic      pend_q, pend_d;
  logic      busy;

  assign busy = pend_q || (phase_q != PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    pend_d   = pend_q;
    load     = 1'b0;
    shift    = 1'b0;
    fill     = 1'b0;
    done_set = 1'b0;
    if (wr_en && !busy) begin
      load   = 1'b1;
      pend_d = 1'b1;
    end
    if (roll) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (pend_q) begin
            phase_d = PH_START;
            pend_d  = 1'b0;
          end
        end
        PH_START: phase_d = PH_DATA;
        PH_DATA: begin
          shift   = 1'b1;
          fill    = 1'b1;
          phase_d = PH_SHIFT;
        end
        PH_SHIFT: begin
          shift = 1'b1;
          if (end_pat) begin
            done_set = 1'b1;
            phase_d  = PH_IDLE;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_IDLE:  txd = 1'b1;
      PH_START: txd = 1'b0;
      default:  txd = sr_lsb;
    endcase
  end

  AST_START_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_START && $past(phase_q) == PH_IDLE) |-> $past(roll && pend_q)); // R3

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && wr_en) |=> $stable(pend_q) || !pend_q); // R6

endmodule

// File: rtl/nbtx_serializer.sv
module nbtx_serializer #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              bit9,
  input  logic              done_clr,
  output logic              txd,
  output logic              done
);
  localparam int SR_W = DATA_W + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic roll;
  logic load, shift, fill, done_set;
  logic sr_lsb, end_pat;
  logic done_q, done_d;

  nbtx_baud_div #(.OVERSAMPLE(OVERSAMPLE)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (bit_tick),
    .roll  (roll)
  );

  nbtx_shreg #(.SR_W(SR_W)) u_sr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val ({bit9, wr_byte}),
    .shift    (shift),
    .fill     (fill),
    .lsb      (sr_lsb),
    .end_pat  (end_pat)
  );

  nbtx_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .roll     (roll),
    .wr_en    (wr_en),
    .sr_lsb   (sr_lsb),
    .end_pat  (end_pat),
    .load     (load),
    .shift    (shift),
    .fill     (fill),
    .done_set (done_set),
    .txd      (txd)
  );

  always_comb begin
    done_d = done_q;
    if (done_clr) done_d = 1'b0;
    if (done_set) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign done = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !done_clr) |=> done); // R5

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_clr && !done_set) |=> !done); // R5

  AST_DONE_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(done) |-> txd); // R4

  AST_TXD_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(roll) |-> $stable(txd)); // R3

endmodule

// File: tb/nbtx_serializer_test.sv
module nbtx_serializer_test;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic       wr_en;
  logic [7:0] wr_byte;
  logic       bit9;
  logic       done_clr;
  logic       txd;
  logic       done;

  int checks;
  int fails;
  int tcnt;
  int tick_mode;
  bit roll;
  bit finished;

  nbtx_serializer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .wr_en    (wr_en),
    .wr_byte  (wr_byte),
    .bit9     (bit9),
    .done_clr (done_clr),
    .txd      (txd),
    .done     (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic exp_bit(int k, logic [7:0] d, logic b9);
    if (k == 1)             return 1'b0;
    if (k >= 2 && k <= 9)   return d[k-2];
    if (k == 10)            return b9;
    return 1'b1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    if (tick_mode == 1)      bit_tick = 1'b1;
    else if (tick_mode == 2) bit_tick = 1'b0;
    else                     bit_tick = (($urandom % 4) != 0);
    @(posedge clk);
    roll = 1'b0;
    if (bit_tick) begin
      if (tcnt == 15) begin
        roll = 1'b1;
        tcnt = 0;
      end else begin
        tcnt++;
      end
    end
    @(negedge clk);
  endtask

  // align: 0 random, 1 write on rollover cycle, 2 write just after rollover
  // inj: 0 none, 1 write while pending, 2 write mid-frame
  task automatic do_frame(logic [7:0] d, logic b9, int align, int inj);
    logic pre_done;
    int   k;
    int   kinj;
    bit   first;
    pre_done = done;
    kinj = 1 + ($urandom % 9);
    if (align == 1) begin
      while (tcnt != 15) cyc();
      tick_mode = 1;
    end else if (align == 2) begin
      roll = 1'b0;
      while (!roll) cyc();
    end
    wr_en = 1'b1; wr_byte = d; bit9 = b9;
    cyc();
    tick_mode = 0;
    wr_en = 1'b0;
    wr_byte = $urandom;
    check("R7", txd, 1'b1);
    k = 0;
    first = 1'b1;
    while (k < 11) begin
      bit9 = $urandom;
      if ((inj == 1 && first) || (inj == 2 && k == kinj)) begin
        wr_en = 1'b1;
        wr_byte = ~d;
        bit9 = ~b9;
        inj = 0;
      end
      first = 1'b0;
      cyc();
      wr_en = 1'b0;
      if (roll) k++;
      if (k == 0) check("R7", txd, 1'b1);
      else if (k == 1) check("R3", txd, 1'b0);
      else if (k == 10) check("R8", txd, exp_bit(k, d, b9));
      else if (k < 11) check("R2", txd, exp_bit(k, d, b9));
      if (k < 11) check("R6", done, pre_done);
    end
    check("R4", done, 1'b1);
    check("R4", txd, 1'b1);
  endtask

  task automatic gap(int n, bit clr);
    for (int i = 0; i < n; i++) begin
      cyc();
      check("R7", txd, 1'b1);
      check("R5", done, 1'b1);
    end
    if (clr) begin
      done_clr = 1'b1;
      cyc();
      done_clr = 1'b0;
      check("R5", done, 1'b0);
      check("R7", txd, 1'b1);
    end
  endtask

  initial begin
    checks = 0; fails = 0; tcnt = 0; tick_mode = 2; roll = 1'b0; finished = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bit_tick = 1'b0; wr_en = 1'b0; wr_byte = '0; bit9 = 1'b0; done_clr = 1'b0;
    repeat (5) @(negedge clk);
    check("R1", txd, 1'b1);
    check("R1", done, 1'b0);
    rst_n = 1'b1;
    repeat (4) cyc();
    tcnt = 0;
    check("R1", txd, 1'b1);
    check("R1", done, 1'b0);
    tick_mode = 0;

    // directed corners
    do_frame(8'h00, 1'b0, 0, 0); gap(3, 1'b1);
    do_frame(8'hFF, 1'b1, 0, 0); gap(0, 1'b0);
    do_frame(8'h02, 1'b0, 1, 0); gap(2, 1'b1); // R3 write in rollover cycle
    do_frame(8'hA5, 1'b1, 2, 0); gap(1, 1'b0); // R3 write after rollover
    do_frame(8'h5A, 1'b0, 0, 1); gap(1, 1'b1); // R6 write while pending
    do_frame(8'h3C, 1'b1, 0, 2); gap(0, 1'b1); // R6 write mid-frame
    do_frame(8'h81, 1'b0, 0, 0);               // R9 back-to-back
    do_frame(8'h7E, 1'b1, 0, 0); gap(2, 1'b1);

    for (int n = 0; n < 40; n++) begin
      do_frame(8'($urandom), 1'($urandom), int'($urandom % 3), int'($urandom % 3));
      gap(int'($urandom % 4), 1'($urandom));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule